// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Generator

This block drives one output pin with a pulse train whose period and high-time are set by software. It has its own up-counter. The counter steps only when a clock-enable line is high. That line is picked from a shared bus of prescaled enables, so one system clock can serve many channels running at different rates.

Software writes the period and the width into holding registers. The running pulse uses a separate pair of active registers. The holding values are copied into the active pair only when a new period begins, so a write in the middle of a period never cuts or stretches the pulse in progress.

The block also provides:
- a polarity choice;
- a sticky period-start flag with an interrupt request;
- a readback of the actual pin level.

While the generator is switched off, the pin is a plain software-driven output.

Top module: `pwm_dbuf_top`

## Requirements
- R1: Register map: address 0 is control, address 1 is period holding, address 2 is width holding, address 3 is status. A write lands in the addressed register at the next clock edge, and all four read back on `reg_rdata_o` combinationally. The control bits are: 0 run enable, 1 active-low polarity, 2 interrupt enable, 3 port data, 6:4 tick select.
- R2: When the run enable goes from 0 to 1, the first clock edge starts a period at once, without waiting for a tick. At that edge the counter becomes 1 and the active registers take the holding values. Re-enabling always restarts from count 1.
- R3: While running, the counter steps on each selected tick from 1 up to the active period P, then returns to 1 and starts a new period. The pulse is active for counts 1 to W, so it is active for W of every P ticks when 0 < W < P.
- R4: A width of 0 keeps the pin at the inactive level for the whole period. A width equal to or greater than the period keeps it at the active level for the whole period.
- R5: A write to the period or width holding register while running does not change the current period. The new value takes effect from the next period start.
- R6: With control bit 1 at 0, the active level is high. With control bit 1 at 1, the pin is inverted and the active level is low.
- R7: Status bit 0 is set at every period start, including the start caused by enabling. It stays set until software writes 1 to status bit 0. If a period start falls on the same edge as the clear, the flag stays set.
- R8: `irq_o` is high exactly when status bit 0 and control bit 2 are both 1.
- R9: Status bit 1 reads back the current level of `pwm_pin_o`.
- R10: With control bit 0 at 0, `pwm_pin_o` follows control bit 3 and the counter is held at zero.
- R11: Control bits 6:4 select which line of `ticks_i` advances the counter. Pulses on the other lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ticks_i | input | NUM_TICKS (8) | Bus of prescaled clock-enable lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Read data for the addressed register |
| pwm_pin_o | output | 1 | Pulse output or port bit |
| irq_o | output | 1 | Period-start interrupt request |

## Verification
The bench builds the block with CNT_W = 8. This makes the full-scale period of 255 ticks short enough to sweep inside one table entry, next to the single-tick period and the 0% and 100% widths. The tick select stays at its fixed width of three bits, giving eight lines. Line 0 is held high so that most tests run at one tick per clock. A slower line on select 3 shows that only the chosen line advances the counter: its pulse rate differs from the rate line 0 would give.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int TICK_SEL_W = 3;
    localparam int NUM_TICKS  = 1 << TICK_SEL_W;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WID  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    // packed MSB first: bit 0 is run enable
    typedef struct packed {
        logic [TICK_SEL_W-1:0] tick_sel;
        logic                  gpo;
        logic                  irq_en;
        logic                  pol_low;
        logic                  enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel #(
    parameter int NUM_TICKS = 8,
    localparam int SEL_W = (NUM_TICKS > 1) ? $clog2(NUM_TICKS) : 1
) (
    input  logic [NUM_TICKS-1:0] ticks_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 tick_o
);

    logic [NUM_TICKS-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_TICKS; g++) begin : g_line
            assign hit[g] = ticks_i[g] && (sel_i == SEL_W'(g));
        end
    endgenerate

    assign tick_o = |hit;

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic              period_start_i,
    input  logic              pin_i,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  per_hold_o,
    output logic [CNT_W-1:0]  wid_hold_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  rdata_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
        logic             flag;
    } regs_t;

    regs_t state_d, state_q;
    logic  clr_req;

    always_comb begin
        state_d = state_q;
        clr_req = wr_i && (addr_i == ADDR_STAT) && wdata_i[0];
        if (wr_i) begin
            unique case (addr_i)
                ADDR_CTRL: state_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
                ADDR_PER:  state_d.per  = wdata_i;
                ADDR_WID:  state_d.wid  = wdata_i;
                default:   ;
            endcase
        end
        if (period_start_i) begin
            state_d.flag = 1'b1;
        end else if (clr_req) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: rdata_o[CTRL_W-1:0] = state_q.ctrl;
            ADDR_PER:  rdata_o = state_q.per;
            ADDR_WID:  rdata_o = state_q.wid;
            default:   rdata_o[1:0] = {pin_i, state_q.flag};
        endcase
    end

    assign ctrl_o     = state_q.ctrl;
    assign per_hold_o = state_q.per;
    assign wid_hold_o = state_q.wid;
    assign flag_o     = state_q.flag;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_i |=> flag_o); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_req) |=> flag_o); // R7

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] per_hold_i,
    input  logic [CNT_W-1:0] wid_hold_i,
    output logic             period_start_o,
    output logic             active_o,
    output logic             running_o
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] wid;
    } core_t;

    core_t state_d, state_q;
    logic  wrap;

    always_comb begin
        state_d        = state_q;
        period_start_o = 1'b0;
        wrap           = tick_i && (state_q.cnt >= state_q.per);
        if (!enable_i) begin
            state_d.run = 1'b0;
            state_d.cnt = '0;
        end else if (!state_q.run || wrap) begin
            period_start_o = 1'b1;
            state_d.run    = 1'b1;
            state_d.cnt    = CNT_W'(1);
            state_d.per    = per_hold_i;
            state_d.wid    = wid_hold_i;
        end else if (tick_i) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active_o  = state_q.run && (state_q.wid != '0) && (state_q.cnt <= state_q.wid);
    assign running_o = state_q.run;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> (state_q.cnt != '0) &&
                        ((state_q.cnt <= state_q.per) || (state_q.cnt == CNT_W'(1)))); // R3

    AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && !period_start_o) |=> ($stable(state_q.per) && $stable(state_q.wid))); // R5

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (!state_q.run && (state_q.cnt == '0))); // R10

    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && (state_q.per != '0) && (state_q.wid >= state_q.per)) |-> active_o); // R4

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] ticks_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [CNT_W-1:0]     reg_wdata_i,
    output logic [CNT_W-1:0]     reg_rdata_o,
    output logic                 pwm_pin_o,
    output logic                 irq_o
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_hold;
    logic [CNT_W-1:0] wid_hold;
    logic             flag;
    logic             tick;
    logic             period_start;
    logic             active;
    logic             running;

    pwm_tick_sel #(
        .NUM_TICKS (NUM_TICKS)
    ) u_tick_sel (
        .ticks_i (ticks_i),
        .sel_i   (ctrl.tick_sel),
        .tick_o  (tick)
    );

    pwm_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_i           (reg_wr_i),
        .addr_i         (reg_addr_i),
        .wdata_i        (reg_wdata_i),
        .period_start_i (period_start),
        .pin_i          (pwm_pin_o),
        .ctrl_o         (ctrl),
        .per_hold_o     (per_hold),
        .wid_hold_o     (wid_hold),
        .flag_o         (flag),
        .rdata_o        (reg_rdata_o)
    );

    pwm_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable_i       (ctrl.enable),
        .tick_i         (tick),
        .per_hold_i     (per_hold),
        .wid_hold_i     (wid_hold),
        .period_start_o (period_start),
        .active_o       (active),
        .running_o      (running)
    );

    assign pwm_pin_o = ctrl.enable ? (active ^ ctrl.pol_low) : ctrl.gpo;
    assign irq_o     = flag && ctrl.irq_en;

    AST_START_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> running); // R2

endmodule

// File: tb/pwm_dbuf_top_tb_top.sv
module pwm_dbuf_top_tb_top;

    localparam int CW = 8;
    localparam int NT = 8;

    // fields: [31:24] period, [23:16] width, [15:8] polarity, [7:0] expected high samples
    localparam logic [31:0] VEC [8] = '{
        32'h0A_03_00_03, 32'h0A_00_00_00, 32'h0A_0A_00_0A, 32'h0A_0F_00_0A,
        32'h0A_03_01_07, 32'hFF_80_00_80, 32'h01_01_00_01, 32'h06_00_01_06
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] ticks;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          pin;
    logic          irq;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    int            tcnt = 0;

    always #2 clk = ~clk;
    always @(negedge clk) tcnt <= tcnt + 1;
    assign ticks = {4'b0000, (tcnt[1:0] == 2'b00), 2'b00, 1'b1};

    pwm_dbuf_top #(.CNT_W(CW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ticks_i     (ticks),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_pin_o   (pin),
        .irq_o       (irq)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [CW-1:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin) c++;
        end
    endtask

    initial begin
        int v;
        int c;
        repeat (3) @(negedge clk);
        check("R1 reset pin", int'(pin), 0);
        check("R8 reset irq", int'(irq), 0);
        rd_reg(2'd0, v); check("R1 reset ctrl", v, 0);
        rd_reg(2'd3, v); check("R7 reset status", v, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 readback, R10 port mode, R9 pin status
        wr_reg(2'd1, 8'h5A);
        wr_reg(2'd2, 8'h21);
        wr_reg(2'd0, 8'h3C);
        rd_reg(2'd1, v); check("R1 period readback", v, 'h5A);
        rd_reg(2'd2, v); check("R1 width readback", v, 'h21);
        rd_reg(2'd0, v); check("R1 ctrl readback", v, 'h3C);
        check("R10 port data high", int'(pin), 1);
        rd_reg(2'd3, v); check("R9 status pin high", v, 2);
        wr_reg(2'd0, 8'h00);
        check("R10 port data low", int'(pin), 0);
        rd_reg(2'd3, v); check("R9 status pin low", v, 0);

        // R3 R4 R6 R2 table walk
        for (int k = 0; k < 8; k++) begin
            wr_reg(2'd0, 8'h00);
            wr_reg(2'd1, VEC[k][31:24]);
            wr_reg(2'd2, VEC[k][23:16]);
            wr_reg(2'd0, {6'b0, VEC[k][8], 1'b1});
            count_high(int'(VEC[k][31:24]), c);
            check($sformatf("R3 R4 R6 vector %0d", k), c, int'(VEC[k][7:0]));
        end

        // R5: width change mid-period waits for the boundary
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd10);
        wr_reg(2'd2, 8'd3);
        wr_reg(2'd0, 8'h01);
        wr_reg(2'd2, 8'd7);
        count_high(9, c);
        check("R5 current period keeps old width", c, 2);
        count_high(10, c);
        check("R5 next period uses new width", c, 7);

        // R7 R8 flag and interrupt
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd3, 8'h01);
        rd_reg(2'd3, v); check("R7 flag cleared", v, 0);
        wr_reg(2'd1, 8'd200);
        wr_reg(2'd2, 8'd5);
        wr_reg(2'd0, 8'h05);
        @(negedge clk);
        rd_reg(2'd3, v); check("R7 flag set at enable", v & 1, 1);
        check("R8 irq with enable", int'(irq), 1);
        wr_reg(2'd3, 8'h01);
        rd_reg(2'd3, v); check("R7 flag write-one clear", v & 1, 0);
        check("R8 irq follows flag", int'(irq), 0);
        wr_reg(2'd0, 8'h01);
        repeat (200) @(negedge clk);
        rd_reg(2'd3, v); check("R7 flag set at next period", v & 1, 1);
        check("R8 irq masked", int'(irq), 0);
        check("R9 status pin matches", (v >> 1) & 1, int'(pin));
        wr_reg(2'd0, 8'h05);
        check("R8 irq unmasked", int'(irq), 1);

        // R11 tick line select
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd4);
        wr_reg(2'd2, 8'd1);
        wr_reg(2'd0, 8'h31);
        repeat (20) @(negedge clk);
        begin
            int rises;
            logic prev;
            rises = 0;
            @(negedge clk);
            prev = pin;
            for (int i = 0; i < 32; i++) begin
                @(negedge clk);
                if (pin && !prev) rises++;
                prev = pin;
            end
            check("R11 selected tick rate", rises, 2);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule